// File: doc/BRIEF.md
# Load Miss Dependency Interlock

This block is the hazard unit of a five-stage in-order integer pipeline whose data cache can miss. A load that misses does not freeze the pipeline. Instead, the unit takes note of the load's destination register while the cache runs its refill. Later instructions keep moving through execute, memory and writeback as long as they neither read nor write that register. An instruction that does touch it is held in the execute stage, one cycle at a time, until the refill has finished.

The unit receives each instruction's register fields as the instruction leaves decode and keeps its own copy of the execute-stage occupant. It also gets a one-cycle miss pulse from the memory stage, which carries the load's destination, and a pulse on the last refill cycle. From these it drives three stall lines: one for the execute stage, one for a second missing load in the memory stage, and one for the whole pipeline on a writeback collision. It also drives the register-file write port select. The refilled load writes back in the cycle after the last refill cycle. Independent instructions that were issued after the load may therefore retire before it does.

Top module: `load_miss_interlock`

## Requirements
- R1: After reset, ex_stall_o, mem_stall_o, wb_stall_o and wb_en_o are all 0.
- R2: While a miss is pending, an instruction in execute is not stalled if none of its enabled source fields and not its enabled destination equal the pending register. A source field whose enable is 0 is ignored even if it holds the pending number.
- R3: An instruction that reads the pending register through either source field has ex_stall_o high in every cycle from the cycle after the miss pulse up to and including the cycle in which refill_done_i is high. ex_stall_o is low in the following cycle.
- R4: An instruction whose enabled destination equals the pending register is stalled in execute in the same way as a reader.
- R5: Register 0 never causes a dependency stall. A miss whose destination is 0 produces no register-file write when its refill completes (wb_en_o is 0 in that cycle).
- R6: Only one miss is outstanding. A miss pulse that arrives while one is pending raises mem_stall_o in that cycle, including the cycle in which refill_done_i is high. The held miss is accepted, with mem_stall_o low, in the first cycle after the earlier refill ends, and its register then becomes the pending one.
- R7: In the cycle after refill_done_i, wb_en_o = 1, wb_refill_o = 1 and wb_rd_o equals the missing load's destination.
- R8: When the refill writeback and a pipeline writeback (wb_valid_i) fall in the same cycle, the refill is written (wb_refill_o = 1), and wb_stall_o = 1 holds the pipeline instruction. In the next cycle the pipeline instruction is written, with wb_refill_o = 0, wb_rd_o = wb_rd_i and wb_stall_o = 0.
- R9: Consider a load that misses with four refill cycles, followed by two independent instructions and then a reader of the load's destination. The reader is stalled for exactly three cycles. The register-file writes come in the order: first independent, second independent, load (from refill), reader.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_valid_i | input | 1 | Decode stage holds a valid instruction |
| id_rs_i | input | 5 | First source register number |
| id_rs_en_i | input | 1 | First source is read |
| id_rt_i | input | 5 | Second source register number |
| id_rt_en_i | input | 1 | Second source is read |
| id_rd_i | input | 5 | Destination register number |
| id_rd_we_i | input | 1 | Destination is written |
| miss_i | input | 1 | Load in memory stage missed the data cache |
| miss_rd_i | input | 5 | Destination of the missing load |
| refill_done_i | input | 1 | Last refill cycle of the outstanding miss |
| wb_valid_i | input | 1 | Pipeline instruction in writeback writes a register |
| wb_rd_i | input | 5 | Destination of the pipeline writeback |
| ex_stall_o | output | 1 | Hold execute and earlier stages, bubble into memory |
| mem_stall_o | output | 1 | Hold memory and earlier stages (second miss) |
| wb_stall_o | output | 1 | Hold the whole pipeline one cycle (writeback collision) |
| wb_en_o | output | 1 | Register-file write enable |
| wb_refill_o | output | 1 | Write data comes from the refill path |
| wb_rd_o | output | 5 | Register-file write address |

## Verification
The replayed four-instruction sequence targets the stall window. If the pending mark is cleared one cycle early, the count drops to two stalls. If it is cleared one cycle late, the count rises to four. Other directed cases cover a source field that holds the pending number with its enable low, a write-only instruction aimed at the pending register, and a miss to register 0. A design that gets these wrong either stalls without need or lets a later write be overwritten by stale refill data. A second miss is issued both in the middle of the refill and in the refill's final cycle, which catches a tracker that drops or overwrites the first miss. A forced collision between the refill writeback and a pipeline writeback shows whether the refill is given priority and whether the displaced write is lost.

// File: rtl/lmi_pkg.sv
package lmi_pkg;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned NUM_SRC = 2;

  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef struct packed {
    logic                        valid;
    logic     [NUM_SRC-1:0]      src_en;
    reg_idx_t [NUM_SRC-1:0]      src;
    logic                        dst_we;
    reg_idx_t                    dst;
  } ex_slot_t;

  typedef enum logic {
    WB_PIPE   = 1'b0,
    WB_REFILL = 1'b1
  } wb_src_e;
endpackage

// File: rtl/lmi_miss_tracker.sv
module lmi_miss_tracker
  import lmi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     miss_i,
  input  reg_idx_t miss_rd_i,
  input  logic     refill_done_i,
  output logic     busy_o,
  output reg_idx_t pend_rd_o,
  output logic     pend_live_o,
  output logic     mem_stall_o,
  output logic     refill_wb_o
);
  logic     busy_q;
  reg_idx_t rd_q;
  logic     rwb_q;
  logic     accept;
  logic     finish;

  assign accept = miss_i & ~busy_q;
  assign finish = refill_done_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= '0;
      rwb_q  <= 1'b0;
    end else begin
      rwb_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        rd_q   <= miss_rd_i;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  // rd_q stays valid through the refill writeback cycle: a new miss is
  // accepted at the earliest at the end of that cycle.
  assign busy_o      = busy_q;
  assign pend_rd_o   = rd_q;
  assign pend_live_o = busy_q & (rd_q != '0);
  assign mem_stall_o = miss_i & busy_q;
  assign refill_wb_o = rwb_q;
endmodule

// File: rtl/lmi_dep_check.sv
module lmi_dep_check
  import lmi_pkg::*;
(
  input  ex_slot_t slot_i,
  input  logic     pend_live_i,
  input  reg_idx_t pend_rd_i,
  output logic     hit_o
);
  logic [NUM_SRC-1:0] src_hit;
  logic               dst_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_hit[g] = slot_i.src_en[g] && (slot_i.src[g] == pend_rd_i);
  end

  // write-after-write: a younger write must not be clobbered by late refill data
  assign dst_hit = slot_i.dst_we && (slot_i.dst == pend_rd_i);
  assign hit_o   = slot_i.valid && pend_live_i && ((|src_hit) || dst_hit);
endmodule

// File: rtl/lmi_ex_slot.sv
module lmi_ex_slot
  import lmi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     advance_i,
  input  ex_slot_t slot_i,
  output ex_slot_t slot_o
);
  ex_slot_t slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        slot_q <= '0;
    else if (advance_i) slot_q <= slot_i;
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/lmi_wb_arb.sv
module lmi_wb_arb
  import lmi_pkg::*;
(
  input  logic     refill_wb_i,
  input  reg_idx_t refill_rd_i,
  input  logic     pipe_valid_i,
  input  reg_idx_t pipe_rd_i,
  output logic     wb_en_o,
  output wb_src_e  wb_src_o,
  output reg_idx_t wb_rd_o,
  output logic     wb_stall_o
);
  always_comb begin
    if (refill_wb_i) begin
      wb_src_o = WB_REFILL;
      wb_rd_o  = refill_rd_i;
      wb_en_o  = (refill_rd_i != '0);
    end else begin
      wb_src_o = WB_PIPE;
      wb_rd_o  = pipe_rd_i;
      wb_en_o  = pipe_valid_i;
    end
  end

  // refill owns the port; the pipeline writer retries next cycle
  assign wb_stall_o = refill_wb_i & pipe_valid_i;
endmodule

// File: rtl/load_miss_interlock.sv
module load_miss_interlock
  import lmi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_valid_i,
  input  logic [REG_AW-1:0] id_rs_i,
  input  logic              id_rs_en_i,
  input  logic [REG_AW-1:0] id_rt_i,
  input  logic              id_rt_en_i,
  input  logic [REG_AW-1:0] id_rd_i,
  input  logic              id_rd_we_i,
  input  logic              miss_i,
  input  logic [REG_AW-1:0] miss_rd_i,
  input  logic              refill_done_i,
  input  logic              wb_valid_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  output logic              ex_stall_o,
  output logic              mem_stall_o,
  output logic              wb_stall_o,
  output logic              wb_en_o,
  output logic              wb_refill_o,
  output logic [REG_AW-1:0] wb_rd_o
);
  ex_slot_t id_slot, ex_slot;
  logic     trk_busy, trk_live, trk_rwb;
  reg_idx_t trk_rd;
  logic     dep_hit, advance;
  wb_src_e  wb_src;

  always_comb begin
    id_slot        = '0;
    id_slot.valid  = id_valid_i;
    id_slot.src[0] = id_rs_i;
    id_slot.src[1] = id_rt_i;
    id_slot.src_en = {id_rt_en_i, id_rs_en_i};
    id_slot.dst    = id_rd_i;
    id_slot.dst_we = id_rd_we_i;
  end

  assign advance = ~dep_hit & ~mem_stall_o & ~wb_stall_o;

  lmi_ex_slot u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .advance_i (advance),
    .slot_i    (id_slot),
    .slot_o    (ex_slot)
  );

  lmi_miss_tracker u_trk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .miss_i        (miss_i),
    .miss_rd_i     (miss_rd_i),
    .refill_done_i (refill_done_i),
    .busy_o        (trk_busy),
    .pend_rd_o     (trk_rd),
    .pend_live_o   (trk_live),
    .mem_stall_o   (mem_stall_o),
    .refill_wb_o   (trk_rwb)
  );

  lmi_dep_check u_dep (
    .slot_i      (ex_slot),
    .pend_live_i (trk_live),
    .pend_rd_i   (trk_rd),
    .hit_o       (dep_hit)
  );

  lmi_wb_arb u_arb (
    .refill_wb_i  (trk_rwb),
    .refill_rd_i  (trk_rd),
    .pipe_valid_i (wb_valid_i),
    .pipe_rd_i    (wb_rd_i),
    .wb_en_o      (wb_en_o),
    .wb_src_o     (wb_src),
    .wb_rd_o      (wb_rd_o),
    .wb_stall_o   (wb_stall_o)
  );

  assign ex_stall_o  = dep_hit;
  assign wb_refill_o = (wb_src == WB_REFILL);
endmodule

// File: rtl/lmi_checker.sv
module lmi_checker
  import lmi_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     refill_done_i,
  input logic     ex_stall_o,
  input logic     mem_stall_o,
  input logic     wb_stall_o,
  input logic     wb_refill_o,
  input reg_idx_t wb_rd_o,
  input logic     busy,
  input reg_idx_t pend_rd
);
  p_refill_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_done_i && busy) |=> (wb_refill_o && wb_rd_o == $past(pend_rd)));

  p_stall_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_done_i && busy) |=> !ex_stall_o);

  p_stall_needs_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_stall_o |-> busy);

  p_zero_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && pend_rd == '0) |-> !ex_stall_o);

  p_one_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stall_o |-> busy);

  p_collide_refill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stall_o |-> wb_refill_o);

  p_collide_retry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stall_o |=> !wb_refill_o);
endmodule

bind load_miss_interlock lmi_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .refill_done_i (refill_done_i),
  .ex_stall_o    (ex_stall_o),
  .mem_stall_o   (mem_stall_o),
  .wb_stall_o    (wb_stall_o),
  .wb_refill_o   (wb_refill_o),
  .wb_rd_o       (wb_rd_o),
  .busy          (trk_busy),
  .pend_rd       (trk_rd)
);

// File: tb/tb_load_miss_interlock.sv
`timescale 1ns/1ps
module tb_load_miss_interlock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       id_valid_i, id_rs_en_i, id_rt_en_i, id_rd_we_i;
  logic [4:0] id_rs_i, id_rt_i, id_rd_i, miss_rd_i, wb_rd_i, wb_rd_o;
  logic       miss_i, refill_done_i, wb_valid_i;
  logic       ex_stall_o, mem_stall_o, wb_stall_o, wb_en_o, wb_refill_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  load_miss_interlock dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    id_valid_i = 0; id_rs_en_i = 0; id_rt_en_i = 0; id_rd_we_i = 0;
    id_rs_i = 0; id_rt_i = 0; id_rd_i = 0;
    miss_i = 0; miss_rd_i = 0; refill_done_i = 0;
    wb_valid_i = 0; wb_rd_i = 0;
  endtask

  task automatic cyc();
    @(negedge clk_i);
    idle();
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic instr(input int rs, input bit rs_en, input int rt, input bit rt_en,
                       input int rd, input bit we);
    id_valid_i = 1; id_rs_i = 5'(rs); id_rs_en_i = rs_en;
    id_rt_i = 5'(rt); id_rt_en_i = rt_en; id_rd_i = 5'(rd); id_rd_we_i = we;
  endtask

  task automatic flush();
    repeat (3) cyc();
  endtask

  task automatic t_reset();
    cyc(); settle();
    check("R1 ex_stall", ex_stall_o, 0);
    check("R1 mem_stall", mem_stall_o, 0);
    check("R1 wb_stall", wb_stall_o, 0);
    check("R1 wb_en", wb_en_o, 0);
  endtask

  task automatic t_independent();
    cyc(); miss_i = 1; miss_rd_i = 5; instr(4, 1, 5, 0, 6, 1); settle();
    cyc(); instr(6, 1, 7, 1, 8, 1); settle();
    check("R2 disabled src holds pending", ex_stall_o, 0);
    cyc(); refill_done_i = 1; settle();
    check("R2 unrelated sources", ex_stall_o, 0);
    flush();
  endtask

  task automatic t_reader();
    cyc(); miss_i = 1; miss_rd_i = 5; instr(1, 1, 5, 1, 9, 1); settle();
    cyc(); settle();
    check("R3 reader stalls first cycle", ex_stall_o, 1);
    cyc(); refill_done_i = 1; settle();
    check("R3 stall through refill_done", ex_stall_o, 1);
    cyc(); settle();
    check("R3 stall released", ex_stall_o, 0);
    check("R7 wb_en", wb_en_o, 1);
    check("R7 wb_refill", wb_refill_o, 1);
    check("R7 wb_rd", wb_rd_o, 5);
    flush();
  endtask

  task automatic t_waw();
    cyc(); miss_i = 1; miss_rd_i = 7; instr(0, 0, 0, 0, 7, 1); settle();
    cyc(); refill_done_i = 1; settle();
    check("R4 writer to pending reg stalls", ex_stall_o, 1);
    cyc(); settle();
    check("R4 writer released", ex_stall_o, 0);
    flush();
  endtask

  task automatic t_zero();
    cyc(); miss_i = 1; miss_rd_i = 0; instr(0, 1, 0, 1, 0, 1); settle();
    cyc(); refill_done_i = 1; settle();
    check("R5 r0 no stall", ex_stall_o, 0);
    cyc(); settle();
    check("R5 r0 refill no write", wb_en_o, 0);
    flush();
  endtask

  task automatic t_second_miss();
    cyc(); miss_i = 1; miss_rd_i = 4; settle();
    check("R6 first miss accepted", mem_stall_o, 0);
    cyc(); miss_i = 1; miss_rd_i = 11; settle();
    check("R6 second miss stalls", mem_stall_o, 1);
    cyc(); miss_i = 1; miss_rd_i = 11; refill_done_i = 1; settle();
    check("R6 stall in refill_done cycle", mem_stall_o, 1);
    cyc(); miss_i = 1; miss_rd_i = 11; settle();
    check("R6 second miss accepted", mem_stall_o, 0);
    check("R7 first refill rd", wb_rd_o, 4);
    cyc(); instr(11, 1, 0, 0, 2, 1); settle();
    cyc(); settle();
    check("R6 new pending reg stalls reader", ex_stall_o, 1);
    refill_done_i = 1;
    cyc(); settle();
    check("R6 released", ex_stall_o, 0);
    flush();
  endtask

  task automatic t_collide();
    cyc(); miss_i = 1; miss_rd_i = 9; settle();
    cyc(); settle();
    cyc(); refill_done_i = 1; settle();
    cyc(); wb_valid_i = 1; wb_rd_i = 12; settle();
    check("R8 collision stall", wb_stall_o, 1);
    check("R8 refill wins", wb_refill_o, 1);
    check("R8 refill rd", wb_rd_o, 9);
    cyc(); wb_valid_i = 1; wb_rd_i = 12; settle();
    check("R8 retry no stall", wb_stall_o, 0);
    check("R8 retry from pipe", wb_refill_o, 0);
    check("R8 retry rd", wb_rd_o, 12);
    check("R8 retry en", wb_en_o, 1);
    flush();
  endtask

  task automatic t_replay();
    int stalls = 0;
    int first_stall = -1;
    int nwb = 0;
    int wb_rd_log [8];
    int wb_rf_log [8];
    for (int k = 0; k < 13; k++) begin
      cyc();
      case (k)
        1: instr(0, 1, 0, 0, 3, 1);
        2: instr(4, 1, 2, 1, 6, 1);
        3: begin instr(5, 1, 2, 1, 7, 1); miss_i = 1; miss_rd_i = 3; end
        4: instr(9, 1, 3, 1, 8, 1);
        5: begin wb_valid_i = 1; wb_rd_i = 6; end
        6: begin wb_valid_i = 1; wb_rd_i = 7; end
        7: refill_done_i = 1;
        10: begin wb_valid_i = 1; wb_rd_i = 8; end
        default: ;
      endcase
      settle();
      if (ex_stall_o) begin
        stalls++;
        if (first_stall < 0) first_stall = k;
      end
      if (wb_en_o && nwb < 8) begin
        wb_rd_log[nwb] = int'(wb_rd_o);
        wb_rf_log[nwb] = int'(wb_refill_o);
        nwb++;
      end
    end
    check("R9 stall count", stalls, 3);
    check("R9 first stall cycle", first_stall, 5);
    check("R9 writeback count", nwb, 4);
    if (nwb == 4) begin
      check("R9 wb0 rd", wb_rd_log[0], 6);
      check("R9 wb1 rd", wb_rd_log[1], 7);
      check("R9 wb2 rd", wb_rd_log[2], 3);
      check("R9 wb2 refill", wb_rf_log[2], 1);
      check("R9 wb3 rd", wb_rd_log[3], 8);
    end
    flush();
  endtask

  initial begin
    idle();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_independent();
    t_reader();
    t_waw();
    t_zero();
    t_second_miss();
    t_collide();
    t_replay();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule